// File: doc/BRIEF.md
# Fetch-Stage Next-Address Predictor

This block produces the next fetch address for an instruction fetch stage. Each cycle it looks up the current fetch PC in a direct-mapped, tagged table of branch targets. Each table entry also holds a 2-bit saturating direction counter and the kind of branch. From that lookup it picks one of three addresses: the sequential address (PC + 4), the target stored in the table, or the top of a small return address stack. It drives the chosen address together with a hit flag and a predicted-taken flag. The lookup is combinational from registered state.

The execute stage reports each resolved branch on a separate port. That report carries the branch PC, its actual direction and target, its kind (conditional, call or return), and the prediction the pipeline carried along from fetch. The block compares the outcome with that prediction and raises a mispredict flag with the correct redirect address in the same cycle. At the next clock edge it trains the table and moves the return stack. Nothing changes state at fetch time.

Top module: `btb_fetch_predictor`

## Requirements
- R1: After reset every table entry is invalid and the return stack is empty, so any fetch PC gives pred_hit=0, pred_taken=0 and pred_next_pc = fetch_pc + 4.
- R2: A fetch PC with no valid entry at its index, or whose 30-bit word-address tag differs from the stored tag, gives pred_hit=0, pred_taken=0 and pred_next_pc = fetch_pc + 4.
- R3: A resolved taken conditional branch (res_kind 2'b00) that misses allocates its entry, with the counter at weakly taken. A later fetch of that PC then gives pred_hit=1, pred_taken=1 and pred_next_pc = the resolved target.
- R4: A conditional entry's counter moves up on taken and down on not-taken, saturating at 0 and 3. The entry predicts taken exactly when the counter is 2 or 3. A hit predicted not-taken gives pred_hit=1, pred_taken=0 and pred_next_pc = fetch_pc + 4.
- R5: A resolved not-taken branch that misses allocates nothing, and its PC still misses afterwards.
- R6: The table is indexed by fetch_pc[IDX_W+1:2]. A taken branch that resolves at an aliasing PC with a different tag replaces the entry, after which the old PC misses.
- R7: A resolved call (res_kind 2'b01) allocates or updates its entry as always taken to its target, and pushes res_pc + 4 onto the return stack.
- R8: A fetch that hits a return entry (res_kind 2'b10) predicts taken to the top of the return stack. Each resolved return pops one entry, so targets come back in last-in, first-out order.
- R9: A fetch that hits a return entry while the return stack is empty gives pred_taken=0 and pred_next_pc = fetch_pc + 4.
- R10: The return stack holds RAS_DEPTH (8) entries. A push onto a full stack overwrites the oldest entry, so after nine calls the pops return the newest eight addresses in reverse order and the stack is then empty.
- R11: While res_valid is high, mispredict is 1 exactly when res_taken differs from res_pred_taken, or when both are taken and res_target differs from res_pred_target. redirect_pc is res_target when res_taken is 1 and res_pc + 4 otherwise.
- R12: A taken resolution that hits an existing entry overwrites its stored target, and the next fetch uses the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| pred_hit | output | 1 | Fetch PC matched a valid table entry |
| pred_taken | output | 1 | Prediction leaves the sequential path |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | ADDR_W | Address of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | ADDR_W | Actual taken target |
| res_kind | input | 2 | 00 conditional, 01 call, 10 return |
| res_pred_taken | input | 1 | Direction predicted at fetch for this branch |
| res_pred_target | input | ADDR_W | Address predicted at fetch for this branch |
| mispredict | output | 1 | Outcome differs from the carried prediction |
| redirect_pc | output | ADDR_W | Correct continuation address |

## Verification
The assertions assume that res_kind never takes the code 2'b11, that calls and returns always resolve with res_taken high, and that res_pred_taken and res_pred_target describe a prediction that could really have been made. The directed stimulus keeps to these rules: it uses only the three defined kinds and always reports calls and returns as taken. It chooses its PCs so that every index collision in the table is intended. The return stack is exercised both below its capacity and one push past it.

// File: rtl/btb_pkg.sv
// Shared types and helpers for the next-fetch-address predictor.
// Assumes the branch kind code fits in two bits and that 2'b11 is never used.
package btb_pkg;

    typedef enum logic [1:0] {
        KIND_COND = 2'b00,
        KIND_CALL = 2'b01,
        KIND_RET  = 2'b10
    } br_kind_e;

    // Counter value for a newly allocated conditional entry: weakly taken.
    localparam logic [1:0] CTR_WEAK_T  = 2'b10;
    // Counter value after reset: weakly not-taken.
    localparam logic [1:0] CTR_WEAK_NT = 2'b01;

    // Two-bit saturating step toward the resolved direction.
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
        if (taken)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/btb_table.sv
// Direct-mapped tagged target table with per-entry direction counters and kind.
// Lookup is combinational from registered state. The update happens at the clock
// edge. Assumes addresses are word aligned, so callers pass word addresses.
module btb_table
    import btb_pkg::*;
#(
    parameter int WA_W  = 30,
    parameter int IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WA_W-1:0] lk_wa,
    output logic            lk_hit,
    output logic [WA_W-1:0] lk_target,
    output br_kind_e        lk_kind,
    output logic [1:0]      lk_ctr,
    input  logic            up_en,
    input  logic [WA_W-1:0] up_wa,
    input  logic            up_taken,
    input  logic [WA_W-1:0] up_target,
    input  br_kind_e        up_kind
);
    localparam int ENTRIES = 1 << IDX_W;

    logic            valid_q  [ENTRIES];
    logic [1:0]      ctr_q    [ENTRIES];
    br_kind_e        kind_q   [ENTRIES];
    logic [WA_W-1:0] tag_q    [ENTRIES];
    logic [WA_W-1:0] target_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic             up_hit;

    // Lookup: compare the stored tag with the fetch word address.
    always_comb begin
        lk_idx    = lk_wa[IDX_W-1:0];
        lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_wa);
        lk_target = target_q[lk_idx];
        lk_kind   = kind_q[lk_idx];
        lk_ctr    = ctr_q[lk_idx];
    end

    // Update-side hit detection for the resolving branch.
    always_comb begin
        up_idx = up_wa[IDX_W-1:0];
        up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_wa);
    end

    // Valid, counter and kind state; cleared by reset, trained at resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
                ctr_q[i]   <= CTR_WEAK_NT;
                kind_q[i]  <= KIND_COND;
            end
        end else if (up_en) begin
            if (up_hit) begin
                ctr_q[up_idx]  <= (up_kind == KIND_COND) ? ctr_step(ctr_q[up_idx], up_taken) : 2'b11;
                kind_q[up_idx] <= up_kind;
            end else if (up_taken) begin
                valid_q[up_idx] <= 1'b1;
                ctr_q[up_idx]   <= (up_kind == KIND_COND) ? CTR_WEAK_T : 2'b11;
                kind_q[up_idx]  <= up_kind;
            end
        end
    end

    // Tag and target storage; written only by taken resolutions, no reset needed.
    always_ff @(posedge clk) begin
        if (up_en && up_taken) begin
            target_q[up_idx] <= up_target;
            if (!up_hit)
                tag_q[up_idx] <= up_wa;
        end
    end

endmodule

// File: rtl/btb_ras.sv
// Circular return address stack. A push onto a full stack overwrites the oldest
// entry, and a pop of an empty stack has no effect. Assumes DEPTH is a power of
// two and that push and pop never arrive in the same cycle.
module btb_ras #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [ADDR_W-1:0]          push_addr,
    input  logic                       pop,
    output logic [ADDR_W-1:0]          top_addr,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]     ptr_q;
    logic [CW-1:0]     cnt_q;

    // Top-of-stack view: the slot below the write pointer.
    always_comb begin
        top_addr = mem_q[ptr_q - PW'(1)];
        empty    = (cnt_q == '0);
        count    = cnt_q;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + PW'(1);
            if (cnt_q != FULL)
                cnt_q <= cnt_q + CW'(1);
        end else if (pop && cnt_q != '0) begin
            ptr_q <= ptr_q - PW'(1);
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Stack storage write.
    always_ff @(posedge clk) begin
        if (push)
            mem_q[ptr_q] <= push_addr;
    end

endmodule

// File: rtl/btb_fetch_predictor.sv
// Next-fetch-address predictor. It picks PC+4, a stored target or the top of the
// return stack, trains at branch resolution, and flags mispredictions. Assumes
// word-aligned PCs, res_kind never 2'b11, and calls and returns resolve taken.
module btb_fetch_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 6,
    parameter int RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] pred_next_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic [1:0]        res_kind,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_target,
    output logic              mispredict,
    output logic [ADDR_W-1:0] redirect_pc
);
    localparam int WA_W = ADDR_W - 2;
    localparam int CW   = $clog2(RAS_DEPTH+1);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [WA_W-1:0]   lk_target;
    br_kind_e          lk_kind;
    logic [1:0]        lk_ctr;
    logic              lk_hit;
    br_kind_e          rkind;
    logic [ADDR_W-1:0] ras_top;
    logic              ras_empty;
    logic [CW-1:0]     ras_count;
    logic [ADDR_W-1:0] fetch_seq, res_seq;

    assign rkind     = br_kind_e'(res_kind);
    assign fetch_seq = fetch_pc + INSN_BYTES;
    assign res_seq   = res_pc + INSN_BYTES;

    btb_table #(.WA_W(WA_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_wa     (fetch_pc[ADDR_W-1:2]),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .lk_kind   (lk_kind),
        .lk_ctr    (lk_ctr),
        .up_en     (res_valid),
        .up_wa     (res_pc[ADDR_W-1:2]),
        .up_taken  (res_taken),
        .up_target (res_target[ADDR_W-1:2]),
        .up_kind   (rkind)
    );

    btb_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (res_valid && rkind == KIND_CALL),
        .push_addr (res_seq),
        .pop       (res_valid && rkind == KIND_RET),
        .top_addr  (ras_top),
        .empty     (ras_empty),
        .count     (ras_count)
    );

    // Select the next fetch address from the lookup result and entry kind.
    always_comb begin
        pred_hit     = lk_hit;
        pred_taken   = 1'b0;
        pred_next_pc = fetch_seq;
        if (lk_hit) begin
            unique case (lk_kind)
                KIND_CALL: begin
                    pred_taken   = 1'b1;
                    pred_next_pc = {lk_target, 2'b00};
                end
                KIND_RET: begin
                    if (!ras_empty) begin
                        pred_taken   = 1'b1;
                        pred_next_pc = ras_top;
                    end
                end
                default: begin
                    if (lk_ctr[1]) begin
                        pred_taken   = 1'b1;
                        pred_next_pc = {lk_target, 2'b00};
                    end
                end
            endcase
        end
    end

    // Compare the resolved outcome with the prediction carried from fetch.
    always_comb begin
        mispredict  = res_valid &&
                      ((res_taken != res_pred_taken) ||
                       (res_taken && (res_target != res_pred_target)));
        redirect_pc = res_taken ? res_target : res_seq;
    end

endmodule

// File: rtl/btb_fetch_predictor_sva.sv
// Property checker for the next-fetch-address predictor, bound to the top module.
// Assumes the same input rules as the top module.
module btb_fetch_predictor_sva #(
    parameter int ADDR_W    = 32,
    parameter int RAS_DEPTH = 8,
    parameter int CW        = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic              res_valid,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic [ADDR_W-1:0] res_pred_target,
    input logic              res_pred_taken,
    input logic              mispredict,
    input logic [CW-1:0]     ras_count
);
    // R1: the first cycle after reset sees no hit.
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !pred_hit);

    // R2: a miss never predicts taken.
    p_miss_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> !pred_taken);

    // R4: the not-taken prediction always follows the sequential path.
    p_fallthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + ADDR_W'(4));

    // R10: return stack occupancy stays within its depth.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ras_count <= CW'(RAS_DEPTH));

    // R11: a direction disagreement always raises mispredict.
    p_dir_mismatch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken != res_pred_taken) |-> mispredict);

    // R11: a matching prediction never raises mispredict.
    p_match_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken == res_pred_taken &&
         (!res_taken || res_target == res_pred_target)) |-> !mispredict);

    // R11: no mispredict without a resolution.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !mispredict);

endmodule

bind btb_fetch_predictor btb_fetch_predictor_sva #(
    .ADDR_W(ADDR_W), .RAS_DEPTH(RAS_DEPTH), .CW(CW)
) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc        (fetch_pc),
    .pred_next_pc    (pred_next_pc),
    .pred_hit        (pred_hit),
    .pred_taken      (pred_taken),
    .res_valid       (res_valid),
    .res_taken       (res_taken),
    .res_target      (res_target),
    .res_pred_target (res_pred_target),
    .res_pred_taken  (res_pred_taken),
    .mispredict      (mispredict),
    .ras_count       (ras_count)
);

// File: tb/tb_btb_fetch_predictor.sv
// Directed bench for the next-fetch-address predictor: one task per scenario.
module tb_btb_fetch_predictor;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] pred_next_pc;
    logic          pred_hit, pred_taken;
    logic          res_valid = 1'b0;
    logic [AW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic [AW-1:0] res_target = '0;
    logic [1:0]    res_kind = 2'b00;
    logic          res_pred_taken = 1'b0;
    logic [AW-1:0] res_pred_target = '0;
    logic          mispredict;
    logic [AW-1:0] redirect_pc;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    btb_fetch_predictor dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_next_pc(pred_next_pc), .pred_hit(pred_hit), .pred_taken(pred_taken),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_kind(res_kind),
        .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
        .mispredict(mispredict), .redirect_pc(redirect_pc)
    );

    // Fetch lookup: drive away from the edge, then compare all three outputs.
    task automatic chk_fetch(input string req, input logic [AW-1:0] pc,
                             input logic ehit, input logic etk, input logic [AW-1:0] enext);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        checks++;
        if (pred_hit !== ehit || pred_taken !== etk || pred_next_pc !== enext) begin
            fails++;
            $display("FAIL %s pc=%h actual hit=%b tk=%b next=%h expected hit=%b tk=%b next=%h",
                     req, pc, pred_hit, pred_taken, pred_next_pc, ehit, etk, enext);
        end
    endtask

    // Resolution: check mispredict/redirect (R11) before the edge, then apply it.
    task automatic resolve(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tgt,
                           input logic [1:0] kind, input logic ptk, input logic [AW-1:0] ptgt);
        logic          emis;
        logic [AW-1:0] ered;
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
        res_kind = kind; res_pred_taken = ptk; res_pred_target = ptgt;
        emis = (tk != ptk) || (tk && tgt != ptgt);
        ered = tk ? tgt : pc + 32'd4;
        #1;
        checks++;
        if (mispredict !== emis || redirect_pc !== ered) begin
            fails++;
            $display("FAIL R11 pc=%h actual mis=%b red=%h expected mis=%b red=%h",
                     pc, mispredict, redirect_pc, emis, ered);
        end
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk_fetch("R1", 32'h1000, 1'b0, 1'b0, 32'h1004);
        chk_fetch("R1", 32'h0100, 1'b0, 1'b0, 32'h0104);
    endtask

    task automatic t_miss;
        chk_fetch("R2", 32'h2000, 1'b0, 1'b0, 32'h2004);
    endtask

    task automatic t_alloc;
        resolve(32'h100, 1'b1, 32'h400, 2'b00, 1'b0, 32'h0);
        chk_fetch("R3", 32'h100, 1'b1, 1'b1, 32'h400);
    endtask

    task automatic t_counter;
        resolve(32'h100, 1'b1, 32'h400, 2'b00, 1'b1, 32'h400);  // 10 -> 11
        resolve(32'h100, 1'b0, 32'h400, 2'b00, 1'b1, 32'h400);  // 11 -> 10
        chk_fetch("R4", 32'h100, 1'b1, 1'b1, 32'h400);
        resolve(32'h100, 1'b0, 32'h400, 2'b00, 1'b1, 32'h400);  // 10 -> 01
        chk_fetch("R4", 32'h100, 1'b1, 1'b0, 32'h104);
        resolve(32'h100, 1'b0, 32'h400, 2'b00, 1'b0, 32'h0);    // 01 -> 00
        resolve(32'h100, 1'b0, 32'h400, 2'b00, 1'b0, 32'h0);    // stays 00
        resolve(32'h100, 1'b1, 32'h400, 2'b00, 1'b0, 32'h0);    // 00 -> 01
        chk_fetch("R4", 32'h100, 1'b1, 1'b0, 32'h104);
        resolve(32'h100, 1'b1, 32'h400, 2'b00, 1'b0, 32'h0);    // 01 -> 10
        chk_fetch("R4", 32'h100, 1'b1, 1'b1, 32'h400);
    endtask

    task automatic t_noalloc;
        resolve(32'h500, 1'b0, 32'h900, 2'b00, 1'b0, 32'h0);
        chk_fetch("R5", 32'h500, 1'b0, 1'b0, 32'h504);
    endtask

    task automatic t_alias;
        chk_fetch("R6", 32'h200, 1'b0, 1'b0, 32'h204);
        resolve(32'h200, 1'b1, 32'h800, 2'b00, 1'b0, 32'h0);
        chk_fetch("R6", 32'h200, 1'b1, 1'b1, 32'h800);
        chk_fetch("R6", 32'h100, 1'b0, 1'b0, 32'h104);
    endtask

    task automatic t_target;
        resolve(32'h200, 1'b1, 32'h900, 2'b00, 1'b1, 32'h800);
        chk_fetch("R12", 32'h200, 1'b1, 1'b1, 32'h900);
    endtask

    task automatic t_call_ret;
        resolve(32'h3008, 1'b1, 32'h6000, 2'b01, 1'b0, 32'h0);  // push 300C
        chk_fetch("R7", 32'h3008, 1'b1, 1'b1, 32'h6000);
        resolve(32'h6010, 1'b1, 32'h300C, 2'b10, 1'b0, 32'h0);  // pop -> empty
        chk_fetch("R9", 32'h6010, 1'b1, 1'b0, 32'h6014);
        resolve(32'h3008, 1'b1, 32'h6000, 2'b01, 1'b1, 32'h6000); // push 300C
        resolve(32'h3044, 1'b1, 32'h6000, 2'b01, 1'b0, 32'h0);    // push 3048
        chk_fetch("R8", 32'h6010, 1'b1, 1'b1, 32'h3048);
        resolve(32'h6010, 1'b1, 32'h3048, 2'b10, 1'b1, 32'h3048);
        chk_fetch("R8", 32'h6010, 1'b1, 1'b1, 32'h300C);
        resolve(32'h6010, 1'b1, 32'h300C, 2'b10, 1'b1, 32'h300C);
        chk_fetch("R9", 32'h6010, 1'b1, 1'b0, 32'h6014);
    endtask

    task automatic t_overflow;
        for (int i = 1; i <= 9; i++)
            resolve(32'h7000 + 32'h100 * i, 1'b1, 32'h6000, 2'b01, 1'b0, 32'h0);
        for (int i = 9; i >= 2; i--) begin
            chk_fetch("R10", 32'h6010, 1'b1, 1'b1, 32'h7000 + 32'h100 * i + 32'd4);
            resolve(32'h6010, 1'b1, 32'h7000 + 32'h100 * i + 32'd4, 2'b10, 1'b1,
                    32'h7000 + 32'h100 * i + 32'd4);
        end
        chk_fetch("R10", 32'h6010, 1'b1, 1'b0, 32'h6014);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss();
        t_alloc();
        t_counter();
        t_noalloc();
        t_alias();
        t_target();
        t_call_ret();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule